// File: doc/BRIEF.md
# Bidirectional General-Purpose I/O Port with Pull-ups

This block is an eight-bit general-purpose I/O port placed between a simple register bus and a row of pads. Every pin has three bits. The first is a direction bit that turns the pad driver on. The second is a data bit, which is the driven level when the pin is an output and the pull-up request when the pin is an input. The third is a read-only sampled copy of the pad level. Software reaches each group of bits through its own register address, using write enable, write data, read enable and read data. Writing ones to the sampled-input address flips the matching data bits, so individual outputs can be toggled without a read-modify-write.

The pad level is passed through a two-stage synchronizer before software can see it. The first stage is a latch that is open while the I/O clock is low, and the second is a flip-flop that captures on the rising edge. A sleep input forces the synchronizer input to zero, so a floating pad cannot cause activity while the chip sleeps. A pull-up-disable input shared by all ports forces every pull-up request low. Reset is asynchronous and clears the direction and data bits, so every pad is tri-stated even when no clock is running.

Top module: `gpio_port`

## Requirements
- R1: While rst_n is low, pad_oe, pad_out and pad_pu are all zero, and the direction and data bits read back as zero once reset is released. Reset acts without a clock edge.
- R2: A write at address 1 (direction) stores wdata on the rising edge. From the next cycle pad_oe equals that value, and a read at address 1 returns it. Bit n set means pin n is an output.
- R3: A write at address 2 (data) stores wdata, and pad_out equals the stored data bits. A read at address 2 returns the stored bits whatever the pad level.
- R4: pad_pu bit n is 1 exactly when direction bit n is 0, data bit n is 1 and pullup_off is 0.
- R5: pullup_off high forces every pad_pu bit to 0 and leaves the stored data bits unchanged.
- R6: A read at address 0 returns the synchronized pad level. A pad change made while the clock is low becomes readable after the next rising edge and not before it.
- R7: A write at address 0 flips every data bit whose wdata bit is 1 and leaves the data bits with a 0 in wdata unchanged.
- R8: While sleep is high, the sampled pad value reads as 0 after two rising edges, and the direction and data bits keep their values.
- R9: A write at address 3 changes no register, and a read at address 3 returns 0.
- R10: rdata is 0 whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 sampled input/toggle, 1 direction, 2 data, 3 unused |
| we | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, zero when rd_en is low |
| sleep | input | 1 | Forces the synchronizer input to zero |
| pullup_off | input | 1 | Global pull-up disable |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven level |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
A corrupted direction bit appears on pad_oe in the cycle after the write and in the address-1 readback. A corrupted data bit appears on pad_out, and on pad_pu for input pins, in the same cycle after the write. A toggle that flips the wrong bits therefore shows up in the data readback one edge later. Faults in the synchronizer show as a sampled value that arrives one edge early or late, or as a nonzero value under sleep. Both can be seen at address 0 within two clock edges of the pad change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PIN  = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_OUT  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      out_q
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] out;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (sel_e'(addr))
                SEL_DIR:  st_d.dir = wdata;
                SEL_OUT:  st_d.out = wdata;
                SEL_PIN:  st_d.out = st_q.out ^ wdata;
                default:  st_d     = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_q = st_q.dir;
    assign out_q = st_q.out;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pin_q
);
    logic [W-1:0] gated;
    logic [W-1:0] lat;
    logic [W-1:0] pin_d;

    assign gated = sleep ? '0 : pad_in;

    always_latch begin
        if (!clk) lat = gated;
    end

    always_comb pin_d = lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end
endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl (
    input  logic dir_bit,
    input  logic out_bit,
    input  logic pullup_off,
    output logic oe,
    output logic drv,
    output logic pu
);
    assign oe  = dir_bit;
    assign drv = out_bit;
    assign pu  = ~dir_bit & out_bit & ~pullup_off;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [W-1:0]      wdata,
    input  logic              rd_en,
    output logic [W-1:0]      rdata,
    input  logic              sleep,
    input  logic              pullup_off,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_pu
);
    logic [W-1:0] dir_q;
    logic [W-1:0] out_q;
    logic [W-1:0] pin_q;

    gpio_regs #(.W(W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .addr  (addr),
        .wdata (wdata),
        .dir_q (dir_q),
        .out_q (out_q)
    );

    gpio_sync #(.W(W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep  (sleep),
        .pad_in (pad_in),
        .pin_q  (pin_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        gpio_padctl u_pad (
            .dir_bit    (dir_q[i]),
            .out_bit    (out_q[i]),
            .pullup_off (pullup_off),
            .oe         (pad_oe[i]),
            .drv        (pad_out[i]),
            .pu         (pad_pu[i])
        );
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel_e'(addr))
                SEL_PIN: rdata = pin_q;
                SEL_DIR: rdata = dir_q;
                SEL_OUT: rdata = out_q;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic [W-1:0]      wdata,
    input logic              rd_en,
    input logic [W-1:0]      rdata,
    input logic              sleep,
    input logic              pullup_off,
    input logic [W-1:0]      pad_oe,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_pu,
    input logic [W-1:0]      dir_q,
    input logic [W-1:0]      out_q,
    input logic [W-1:0]      pin_q
);
    AST_RESET_TRISTATE: assert property (@(posedge clk) !rst_n |-> (pad_oe == '0 && pad_pu == '0)); // R1
    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (we && addr == SEL_DIR) |=> pad_oe == $past(wdata)); // R2
    AST_OUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (we && addr == SEL_OUT) |=> pad_out == $past(wdata)); // R3
    AST_PU_ONLY_INPUTS: assert property (@(posedge clk) disable iff (!rst_n) (pad_pu & pad_oe) == '0); // R4
    AST_PU_DISABLE: assert property (@(posedge clk) disable iff (!rst_n) pullup_off |-> pad_pu == '0); // R5
    AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n) (we && addr == SEL_PIN) |=> out_q == ($past(out_q) ^ $past(wdata))); // R7
    AST_SLEEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ($past(sleep) && $past(sleep, 2)) |-> pin_q == '0); // R8
    AST_NONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (we && addr == SEL_NONE) |=> ($stable(dir_q) && $stable(out_q))); // R9
    AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |-> rdata == '0); // R10
endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .we         (we),
    .wdata      (wdata),
    .rd_en      (rd_en),
    .rdata      (rdata),
    .sleep      (sleep),
    .pullup_off (pullup_off),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_pu     (pad_pu),
    .dir_q      (dir_q),
    .out_q      (out_q),
    .pin_q      (pin_q)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   addr = '0;
    logic         we = 1'b0;
    logic [W-1:0] wdata = '0;
    logic         rd_en = 1'b0;
    logic [W-1:0] rdata;
    logic         sleep = 1'b0;
    logic         pullup_off = 1'b0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_oe, pad_out, pad_pu;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gpio_port #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .sleep(sleep), .pullup_off(pullup_off),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        addr = a; rd_en = 1'b1;
        #0.5;
        d = rdata;
        rd_en = 1'b0;
        #0.1;
    endtask

    task automatic t_reset;
        logic [W-1:0] v;
        check("R1 oe in reset", pad_oe, '0);
        check("R1 pu in reset", pad_pu, '0);
        check("R1 out in reset", pad_out, '0);
        @(negedge clk); rst_n = 1'b1;
        rd(2'd1, v); check("R1 dir after reset", v, '0);
        rd(2'd2, v); check("R1 data after reset", v, '0);
    endtask

    task automatic t_dir_out;
        logic [W-1:0] v;
        wr(2'd1, 8'hF0);
        check("R2 oe", pad_oe, 8'hF0);
        rd(2'd1, v); check("R2 dir readback", v, 8'hF0);
        pad_in = 8'h0F;
        wr(2'd2, 8'hA5);
        check("R3 pad_out", pad_out, 8'hA5);
        rd(2'd2, v); check("R3 data readback not pad", v, 8'hA5);
    endtask

    task automatic t_pullup;
        check("R4 pu inputs only", pad_pu, 8'h05);
        wr(2'd1, 8'h00);
        check("R4 pu all inputs", pad_pu, 8'hA5);
        @(negedge clk); pullup_off = 1'b1; #0.5;
        check("R5 pu forced off", pad_pu, 8'h00);
        begin logic [W-1:0] v; rd(2'd2, v); check("R5 data kept", v, 8'hA5); end
        @(negedge clk); pullup_off = 1'b0; #0.5;
        check("R5 pu restored", pad_pu, 8'hA5);
    endtask

    task automatic t_sample;
        logic [W-1:0] v;
        @(negedge clk); pad_in = 8'h3C;
        rd(2'd0, v); check("R6 not yet visible", v, 8'h0F);
        @(negedge clk);
        rd(2'd0, v); check("R6 visible after edge", v, 8'h3C);
        @(negedge clk); pad_in = 8'hC3;
        @(negedge clk);
        rd(2'd0, v); check("R6 second pattern", v, 8'hC3);
    endtask

    task automatic t_toggle;
        logic [W-1:0] v;
        wr(2'd2, 8'h0F);
        wr(2'd0, 8'h11);
        rd(2'd2, v); check("R7 toggle", v, 8'h1E);
        wr(2'd0, 8'h00);
        rd(2'd2, v); check("R7 zero no change", v, 8'h1E);
        wr(2'd0, 8'hFF);
        rd(2'd2, v); check("R7 toggle all", v, 8'hE1);
    endtask

    task automatic t_sleep;
        logic [W-1:0] v;
        wr(2'd1, 8'h5A);
        @(negedge clk); pad_in = 8'hFF; sleep = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(2'd0, v); check("R8 sleep reads 0", v, 8'h00);
        rd(2'd1, v); check("R8 dir kept", v, 8'h5A);
        rd(2'd2, v); check("R8 data kept", v, 8'hE1);
        sleep = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(2'd0, v); check("R8 wake reads pad", v, 8'hFF);
    endtask

    task automatic t_unused;
        logic [W-1:0] v;
        wr(2'd3, 8'hFF);
        rd(2'd1, v); check("R9 dir untouched", v, 8'h5A);
        rd(2'd2, v); check("R9 data untouched", v, 8'hE1);
        rd(2'd3, v); check("R9 unused reads 0", v, 8'h00);
        addr = 2'd2; #0.5;
        check("R10 idle rdata", rdata, 8'h00);
    endtask

    initial begin
        #1;
        t_reset();
        t_dir_out();
        t_pullup();
        t_sample();
        t_toggle();
        t_sleep();
        t_unused();
        #1;
        rst_n = 1'b0; #1;
        check("R1 async reset oe", pad_oe, '0);
        check("R1 async reset out", pad_out, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule